// File: doc/BRIEF.md
# Sequential Bit-Serial Shifter

This unit performs logical shifts on a register operand by moving the held value one bit position per clock cycle, so the time it takes grows linearly with the requested distance. A caller presents an operand, a direction and a count together with a one-cycle start strobe. It then waits for a single-cycle completion pulse, which arrives with the shifted value, a carry flag and an overflow flag.

Only the low five bits of the requested count are used, so the distance is taken modulo 32. The longest operation therefore iterates at most 31 times, which gives any surrounding control logic a fixed upper bound on how long it can be held off. Shifts to the left fill the vacated low bit with zero. Shifts to the right fill the vacated high bit with zero.

Top module: `seq_shifter`

## Requirements
- R1: After a start is accepted on a clock edge, the unit runs one shift step on each of the next N edges, where N is the effective count. done_o is high after exactly the N-th of those edges, and after the accepting edge itself when N is 0.
- R2: The effective count is the requested count modulo 32, which is bits [4:0] of cnt_i. busy_o never stays high for more than 31 consecutive cycles.
- R3: With dir_i = 0 (left), the result equals the operand moved N places toward the MSB, truncated to WIDTH bits, with zeros entering at bit 0.
- R4: With dir_i = 1 (right), the result equals the operand moved N places toward the LSB, with zeros entering at bit WIDTH-1.
- R5: For N > 0, carry_o holds the last bit that left the operand. For a left shift this is operand bit WIDTH-N, and for a right shift it is operand bit N-1. When N exceeds WIDTH, carry_o is 0.
- R6: For N = 1, ovf_o is the XOR of operand bits WIDTH-1 and WIDTH-2 on a left shift, and operand bit WIDTH-1 on a right shift. For other values of N it is not specified.
- R7: For N = 0, done_o is high in the cycle after the accepting edge, result_o equals the operand, and carry_o and ovf_o keep their previous values.
- R8: busy_o is high in every cycle between the accepting edge and the completion, and low while done_o is high. done_o lasts one cycle unless a new start is accepted during it.
- R9: A start that arrives while busy_o is high is ignored. The running operation finishes with its original operand, direction and count.
- R10: After a synchronous reset, busy_o, done_o, result_o, carry_o and ovf_o are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe, accepted when busy_o is low |
| dir_i | input | 1 | 0 = shift left, 1 = shift right |
| opnd_i | input | WIDTH | Operand captured on acceptance |
| cnt_i | input | CNT_W | Requested distance; only bits [4:0] are used |
| busy_o | output | 1 | High while shift steps are in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | WIDTH | Shifted value, valid with done_o |
| carry_o | output | 1 | Last bit shifted out |
| ovf_o | output | 1 | Overflow flag, defined for a distance of 1 |

## Verification
The assertions assume that start_i, dir_i, opnd_i and cnt_i are known values on every clock edge after reset. They also assume that a start offered while busy_o is high may take any value, because the control logic must drop it. The stimulus changes inputs only on falling edges. It draws counts from the full 8-bit range, so the modulo-32 masking and distances longer than the operand are both exercised. It also deliberately raises start in the middle of a running shift, with a different operand, so that the ignore path is covered.

// File: rtl/seq_shift_pkg.sv
package seq_shift_pkg;

    // Number of count bits kept; the distance is taken modulo 2**CNT_MASK_W
    localparam int CNT_MASK_W = 5;
    localparam int MAX_STEPS  = (1 << CNT_MASK_W) - 1;
    localparam int RUN_CNT_W  = CNT_MASK_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } sh_state_e;

    typedef enum logic {
        DIR_LEFT  = 1'b0,
        DIR_RIGHT = 1'b1
    } sh_dir_e;

    typedef struct packed {
        logic carry;
        logic ovf;
    } sh_flags_t;

    function automatic logic [CNT_MASK_W-1:0] step_down(input logic [CNT_MASK_W-1:0] v);
        return v - {{(CNT_MASK_W-1){1'b0}}, 1'b1};
    endfunction

endpackage

// File: rtl/shift_count_mask.sv
module shift_count_mask
    import seq_shift_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0]      cnt_i,
    output logic [CNT_MASK_W-1:0] eff_o,
    output logic                  zero_o
);
    generate
        if (CNT_W >= CNT_MASK_W) begin : g_trunc
            assign eff_o = cnt_i[CNT_MASK_W-1:0];
        end else begin : g_pad
            assign eff_o = {{(CNT_MASK_W-CNT_W){1'b0}}, cnt_i};
        end
    endgenerate

    assign zero_o = (eff_o == '0);
endmodule

// File: rtl/shift_step_unit.sv
module shift_step_unit
    import seq_shift_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  sh_dir_e          dir_i,
    input  logic [WIDTH-1:0] src_i,
    output logic [WIDTH-1:0] nxt_o,
    output sh_flags_t        flags_o
);
    logic right;
    assign right = (dir_i == DIR_RIGHT);

    // Each bit takes its neighbour; edge bits take zero on the vacated side
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            assign nxt_o[i] = right ? src_i[i+1] : 1'b0;
        end else if (i == WIDTH-1) begin : g_msb
            assign nxt_o[i] = right ? 1'b0 : src_i[i-1];
        end else begin : g_mid
            assign nxt_o[i] = right ? src_i[i+1] : src_i[i-1];
        end
    end

    always_comb begin
        flags_o.carry = right ? src_i[0] : src_i[WIDTH-1];
        flags_o.ovf   = right ? src_i[WIDTH-1] : (nxt_o[WIDTH-1] ^ flags_o.carry);
    end
endmodule

// File: rtl/shift_seq_ctrl.sv
module shift_seq_ctrl
    import seq_shift_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic [CNT_MASK_W-1:0] eff_i,
    input  logic                  zero_i,
    output logic                  accept_o,
    output logic                  step_o,
    output logic                  busy_o,
    output logic                  done_o
);
    sh_state_e             state_q;
    logic [CNT_MASK_W-1:0] rem_q;

    assign accept_o = start_i && (state_q != ST_RUN);
    assign step_o   = (state_q == ST_RUN);
    assign busy_o   = (state_q == ST_RUN);
    assign done_o   = (state_q == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            rem_q   <= '0;
        end else if (accept_o) begin
            rem_q   <= eff_i;
            state_q <= zero_i ? ST_DONE : ST_RUN;
        end else begin
            case (state_q)
                ST_RUN: begin
                    rem_q <= step_down(rem_q);
                    if (rem_q == {{(CNT_MASK_W-1){1'b0}}, 1'b1}) state_q <= ST_DONE;
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R9: a start seen while running leaves the countdown untouched
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && start_i) |=> (rem_q == step_down($past(rem_q))));

    // R8: never running with nothing left to do
    a_r8_run_nonzero: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN) |-> (rem_q != '0));

    // R8: busy and done never overlap
    a_r8_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
        !(busy_o && done_o));

    // R1: the final step leads straight to completion
    a_r1_last_step_done: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && rem_q == {{(CNT_MASK_W-1){1'b0}}, 1'b1}) |=> done_o);
endmodule

// File: rtl/seq_shifter.sv
module seq_shifter
    import seq_shift_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             dir_i,
    input  logic [WIDTH-1:0] opnd_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o,
    output logic             ovf_o
);
    logic [CNT_MASK_W-1:0] eff_cnt;
    logic                  cnt_zero;
    logic                  accept, step;
    logic [WIDTH-1:0]      data_q, data_nxt;
    sh_dir_e               dir_q;
    sh_flags_t             flags_q, flags_nxt;

    shift_count_mask #(.CNT_W(CNT_W)) u_mask (
        .cnt_i  (cnt_i),
        .eff_o  (eff_cnt),
        .zero_o (cnt_zero)
    );

    shift_seq_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .eff_i    (eff_cnt),
        .zero_i   (cnt_zero),
        .accept_o (accept),
        .step_o   (step),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    shift_step_unit #(.WIDTH(WIDTH)) u_step (
        .dir_i   (dir_q),
        .src_i   (data_q),
        .nxt_o   (data_nxt),
        .flags_o (flags_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            dir_q   <= DIR_LEFT;
            flags_q <= '0;
        end else if (accept) begin
            data_q <= opnd_i;
            dir_q  <= sh_dir_e'(dir_i);
        end else if (step) begin
            data_q  <= data_nxt;
            flags_q <= flags_nxt;
        end
    end

    assign result_o = data_q;
    assign carry_o  = flags_q.carry;
    assign ovf_o    = flags_q.ovf;

    // Length of the current busy stretch, for the latency bound
    logic [RUN_CNT_W-1:0] busy_run_q;
    always_ff @(posedge clk) begin
        if (rst || !busy_o) busy_run_q <= '0;
        else                busy_run_q <= busy_run_q + 1'b1;
    end

    a_r2_busy_bounded: assert property (@(posedge clk) disable iff (rst)
        busy_run_q <= RUN_CNT_W'(MAX_STEPS));

    a_r3_left_step: assert property (@(posedge clk) disable iff (rst)
        (step && dir_q == DIR_LEFT) |=> (data_q == {$past(data_q[WIDTH-2:0]), 1'b0}));

    a_r4_right_step: assert property (@(posedge clk) disable iff (rst)
        (step && dir_q == DIR_RIGHT) |=> (data_q == {1'b0, $past(data_q[WIDTH-1:1])}));

    a_r5_carry_left: assert property (@(posedge clk) disable iff (rst)
        (step && dir_q == DIR_LEFT) |=> (carry_o == $past(data_q[WIDTH-1])));

    a_r5_carry_right: assert property (@(posedge clk) disable iff (rst)
        (step && dir_q == DIR_RIGHT) |=> (carry_o == $past(data_q[0])));

    a_r7_zero_hold: assert property (@(posedge clk) disable iff (rst)
        (accept && cnt_zero) |=> (done_o && result_o == $past(opnd_i)
                                  && carry_o == $past(carry_o) && ovf_o == $past(ovf_o)));

    a_r9_no_reload: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> $stable(dir_q));
endmodule

// File: tb/seq_shifter_tb.sv
module seq_shifter_tb;
    localparam int W  = 16;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          start_i, dir_i;
    logic [W-1:0]  opnd_i;
    logic [CW-1:0] cnt_i;
    logic          busy_o, done_o, carry_o, ovf_o;
    logic [W-1:0]  result_o;

    int checks = 0;
    int errors = 0;
    logic exp_carry = 1'b0;
    logic exp_ovf   = 1'b0;
    bit   ovf_known = 1'b1;

    seq_shifter #(.WIDTH(W), .CNT_W(CW)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .dir_i(dir_i), .opnd_i(opnd_i),
        .cnt_i(cnt_i), .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
        .carry_o(carry_o), .ovf_o(ovf_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] ref_result(input logic d, input logic [W-1:0] v, input int n);
        if (n >= W) return '0;
        return d ? (v >> n) : (v << n);
    endfunction

    function automatic logic ref_carry(input logic d, input logic [W-1:0] v, input int n);
        if (n > W) return 1'b0;
        return d ? v[n-1] : v[W-n];
    endfunction

    // One operation; inject != 0 raises start mid-run with another operand
    task automatic run_op(input logic d, input logic [W-1:0] v, input logic [CW-1:0] c, input bit inject);
        int n, k;
        bit busy_bad;
        logic [W-1:0] er;
        n = int'(c) % 32;
        @(negedge clk);
        start_i = 1'b1; dir_i = d; opnd_i = v; cnt_i = c;
        @(negedge clk);
        start_i = 1'b0;
        k = 0; busy_bad = 0;
        while (!done_o && k < 40) begin
            if (!busy_o) busy_bad = 1;
            if (inject && k == 1) begin
                start_i = 1'b1; dir_i = ~d; opnd_i = ~v; cnt_i = 8'd3;
            end
            @(negedge clk);
            start_i = 1'b0;
            k++;
        end
        er = ref_result(d, v, n);
        chk("R1 latency", W'(k), W'(n));
        chk("R8 busy during run", W'(busy_bad), '0);
        chk("R8 busy low at done", W'(busy_o), '0);
        if (inject) chk("R9 ignored start result", result_o, er);
        else if (d) chk("R4 right result", result_o, er);
        else        chk("R3 left result", result_o, er);
        if (n == 0) begin
            chk("R7 zero count carry kept", W'(carry_o), W'(exp_carry));
            if (ovf_known) chk("R7 zero count ovf kept", W'(ovf_o), W'(exp_ovf));
        end else begin
            exp_carry = ref_carry(d, v, n);
            chk("R5 carry", W'(carry_o), W'(exp_carry));
            if (n == 1) begin
                exp_ovf = d ? v[W-1] : (v[W-1] ^ v[W-2]);
                ovf_known = 1'b1;
                chk("R6 overflow", W'(ovf_o), W'(exp_ovf));
            end else begin
                ovf_known = 1'b0;
            end
        end
        @(negedge clk);
        chk("R8 done single pulse", W'(done_o), '0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        process::self().srandom(32'd1234);
        rst = 1'b1; start_i = 1'b0; dir_i = 1'b0; opnd_i = '0; cnt_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R10 reset busy", W'(busy_o), '0);
        chk("R10 reset done", W'(done_o), '0);
        chk("R10 reset result", result_o, '0);
        chk("R10 reset flags", W'({carry_o, ovf_o}), '0);

        // Directed corners
        run_op(1'b0, 16'h1234, 8'd0, 0);   // R7 after reset
        run_op(1'b0, 16'h8001, 8'd1, 0);   // R6 left, carry 1
        run_op(1'b1, 16'h8001, 8'd1, 0);   // R6 right
        run_op(1'b0, 16'h4000, 8'd1, 0);   // R6 left ovf from bit 14
        run_op(1'b1, 16'hFFFF, 8'd16, 0);  // R5 carry = top bit
        run_op(1'b0, 16'hFFFF, 8'd17, 0);  // R5 carry beyond width
        run_op(1'b1, 16'hA5A5, 8'd31, 0);  // R2 maximum
        run_op(1'b0, 16'h00F1, 8'd32, 0);  // R2 wraps to zero
        run_op(1'b1, 16'hBEEF, 8'd36, 0);  // R2 wraps to 4
        run_op(1'b0, 16'hC3C3, 8'd8, 1);   // R9 start during busy
        run_op(1'b1, 16'h9876, 8'd255, 1); // R9 + R2 wrap to 31

        // Random traffic
        for (int i = 0; i < 150; i++) begin
            run_op(1'($urandom), 16'($urandom), 8'($urandom), ($urandom % 8) == 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule